// File: doc/BRIEF.md
# Chained Prescaler Timer with Compare Interrupts

This block is a small timer built from three counting channels. A prescaler channel runs on every system clock. It counts from zero up to a programmable reload value, and each time the count equals that value it inverts a shared tick line. Two main counters advance by one on each rising edge of that line. A main counter therefore steps once every 2×(reload+1) system clocks.

Each main counter owns three compare slots. A compare slot has a 16-bit value, a sticky match flag and an interrupt enable. A single level interrupt output is high while any flag is set together with its enable.

Software drives the block through a one-cycle write strobe with an address and data. Writes load the reload value and the compare values, start or stop channels, clear flags, and clear enables. Writing a compare value also clears that slot's flag and arms its interrupt in the same cycle. All logic runs in the system clock domain. A registered edge detector turns the tick line into a one-cycle advance pulse.

Top module: `tick_chain_timer`

## Requirements
- R1: After reset both counts are 0, all six flags are 0, the tick line is 0 and the interrupt is 0.
- R2: With reload value RC loaded at address 0x0, the prescaler counts 0..RC after a start and inverts the tick line at each match, one inversion every RC+1 clocks. The first inversion comes RC+1 clocks after the start write.
- R3: Control address 0x1 bit 0 starts the prescaler, clearing its count and driving the tick line low. Bit 4 stops it, and while stopped the tick line holds.
- R4: A running main counter increments by one in the clock after each rising edge of the tick line and holds otherwise. Started together with the prescaler, it reaches N exactly RC+2+2×(RC+1)×(N−1) clocks after the start write.
- R5: Control bit 1+c starts main counter c (c = 0 or 1) from zero, and bit 5+c stops it. A stopped counter holds its value while the other keeps counting.
- R6: Main counters wrap from 0xFFFF to 0x0000 on a tick, and compare matches, including a match on 0, still occur after the wrap.
- R7: Flag c×3+k (k = 0,1,2 for slots A,B,C) is set in the clock in which counter c takes a new value equal to slot k's compare value. The flag stays set until cleared.
- R8: A write to address 0x8+4×c+k stores the compare value, clears flag c×3+k and sets its enable, all in that one clock.
- R9: A write to address 0x2 clears each flag whose data bit is 1. A match in the same clock wins and leaves that flag set.
- R10: A write to address 0x3 clears each enable whose data bit is 1. A flag whose enable is clear still sets on a match but does not raise the interrupt.
- R11: The interrupt output is 1 exactly when some flag is set while its enable is set.
- R12: Writes to addresses 0x4–0x7 and to compare slot 3 (0xB, 0xF) change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per high cycle |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| tick_o | output | 1 | Shared tick line driven by the prescaler |
| count_o | output | 32 | Counter 1 value in bits 31:16, counter 0 value in bits 15:0 |
| flag_o | output | 6 | Match flags, bit c×3+k for counter c, slot k |
| irq_o | output | 1 | Combined interrupt |

## Verification
A prescaler count that slips by one cycle moves every counter step, and the bench sees it in the clock before or after the predicted step. Each run is checked one clock early and on the exact clock. A stuck or missed edge detection shows as a count that is wrong by one or more within two tick periods. A flag or enable in the wrong state shows on irq_o in the same clock the bad state appears. This covers a compare write that fails to clear, a clear that beats a match, and a match missed after the wrap.

// File: rtl/tct_pkg.sv
package tct_pkg;
    localparam int NUM_CNT = 2;
    localparam int NUM_CMP = 3;
    localparam int FLAG_W  = NUM_CNT * NUM_CMP;
    localparam int ADDR_W  = 4;

    typedef enum logic [ADDR_W-1:0] {
        ADR_RELOAD   = 4'h0,
        ADR_CTRL     = 4'h1,
        ADR_FLAG_CLR = 4'h2,
        ADR_EN_CLR   = 4'h3
    } reg_addr_e;

    // control word: start bits from START_LSB, stop bits from STOP_LSB
    // index 0 is the prescaler, 1.. are the main counters
    localparam int CTRL_START_LSB = 0;
    localparam int CTRL_STOP_LSB  = 4;
endpackage

// File: rtl/tct_prescaler.sv
module tct_prescaler #(
    parameter int           W        = 16,
    parameter logic [W-1:0] RESET_RC = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         stop_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         tick_o,
    output logic         run_o
);
    typedef struct packed {
        logic         run;
        logic         tick;
        logic [W-1:0] cnt;
        logic [W-1:0] rc;
    } pre_state_t;

    localparam pre_state_t RESET_STATE = '{run: 1'b0, tick: 1'b0, cnt: '0, rc: RESET_RC};

    pre_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.run) begin
            if (s_q.cnt == s_q.rc) begin
                s_d.cnt  = '0;
                s_d.tick = ~s_q.tick;
            end else begin
                s_d.cnt = s_q.cnt + W'(1);
            end
        end
        if (load_i) s_d.rc = load_val_i;
        if (stop_i) s_d.run = 1'b0;
        // start has priority over stop and sets a known phase
        if (start_i) begin
            s_d.run  = 1'b1;
            s_d.cnt  = '0;
            s_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RESET_STATE;
        else        s_q <= s_d;
    end

    assign tick_o = s_q.tick;
    assign run_o  = s_q.run;
endmodule

// File: rtl/tct_rise_det.sv
module tct_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic dly_d, dly_q;

    always_comb dly_d = level_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= 1'b0;
        else        dly_q <= dly_d;
    end

    assign rise_o = level_i & ~dly_q;
endmodule

// File: rtl/tct_channel.sv
module tct_channel #(
    parameter int CNT_W   = 16,
    parameter int NUM_CMP = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [NUM_CMP-1:0] cmp_we_i,
    input  logic [CNT_W-1:0]   cmp_val_i,
    input  logic [NUM_CMP-1:0] flag_clr_i,
    input  logic [NUM_CMP-1:0] en_clr_i,
    output logic [CNT_W-1:0]   count_o,
    output logic [NUM_CMP-1:0] flag_o,
    output logic [NUM_CMP-1:0] en_o,
    output logic               run_o,
    output logic               irq_o
);
    typedef struct packed {
        logic                           run;
        logic [CNT_W-1:0]               cnt;
        logic [NUM_CMP-1:0][CNT_W-1:0]  cmp;
        logic [NUM_CMP-1:0]             flag;
        logic [NUM_CMP-1:0]             en;
    } ch_state_t;

    ch_state_t        s_d, s_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             step;

    always_comb begin
        s_d     = s_q;
        cnt_inc = s_q.cnt + CNT_W'(1);
        step    = s_q.run & adv_i & ~start_i;

        if (step)    s_d.cnt = cnt_inc;
        if (stop_i)  s_d.run = 1'b0;
        if (start_i) begin
            s_d.run = 1'b1;
            s_d.cnt = '0;
        end

        for (int k = 0; k < NUM_CMP; k++) begin
            if (flag_clr_i[k]) s_d.flag[k] = 1'b0;
            // a match beats a clear issued in the same cycle
            if (step && (cnt_inc == s_q.cmp[k])) s_d.flag[k] = 1'b1;
            if (en_clr_i[k]) s_d.en[k] = 1'b0;
            // a compare write drops any stale flag and arms the slot
            if (cmp_we_i[k]) begin
                s_d.cmp[k]  = cmp_val_i;
                s_d.flag[k] = 1'b0;
                s_d.en[k]   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o = s_q.cnt;
    assign flag_o  = s_q.flag;
    assign en_o    = s_q.en;
    assign run_o   = s_q.run;
    assign irq_o   = |(s_q.flag & s_q.en);
endmodule

// File: rtl/tick_chain_timer.sv
module tick_chain_timer
    import tct_pkg::*;
#(
    parameter int              PRE_W    = 16,
    parameter int              CNT_W    = 16,
    parameter int              DATA_W   = 16,
    parameter logic [PRE_W-1:0] RESET_RC = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic                      tick_o,
    output logic [NUM_CNT*CNT_W-1:0]  count_o,
    output logic [FLAG_W-1:0]         flag_o,
    output logic                      irq_o
);
    logic               sel_ctrl, sel_fclr, sel_eclr, sel_reload;
    logic               pre_start, pre_stop, pre_run;
    logic               tick_rise;
    logic [NUM_CNT-1:0] cnt_start, cnt_stop, cnt_run, cnt_irq;
    logic [FLAG_W-1:0]  cmp_we_flat, flag_clr_flat, en_clr_flat, en_all;

    always_comb begin
        sel_reload = wr_en && (wr_addr == ADR_RELOAD);
        sel_ctrl   = wr_en && (wr_addr == ADR_CTRL);
        sel_fclr   = wr_en && (wr_addr == ADR_FLAG_CLR);
        sel_eclr   = wr_en && (wr_addr == ADR_EN_CLR);

        pre_start = sel_ctrl & wr_data[CTRL_START_LSB];
        pre_stop  = sel_ctrl & wr_data[CTRL_STOP_LSB];

        flag_clr_flat = {FLAG_W{sel_fclr}} & wr_data[FLAG_W-1:0];
        en_clr_flat   = {FLAG_W{sel_eclr}} & wr_data[FLAG_W-1:0];

        for (int i = 0; i < NUM_CNT; i++) begin
            cnt_start[i] = sel_ctrl & wr_data[CTRL_START_LSB + 1 + i];
            cnt_stop[i]  = sel_ctrl & wr_data[CTRL_STOP_LSB + 1 + i];
            for (int k = 0; k < NUM_CMP; k++) begin
                cmp_we_flat[i*NUM_CMP + k] = wr_en && wr_addr[3]
                                          && (wr_addr[2] == 1'(i))
                                          && (wr_addr[1:0] == 2'(k));
            end
        end
    end

    tct_prescaler #(.W(PRE_W), .RESET_RC(RESET_RC)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (pre_start),
        .stop_i     (pre_stop),
        .load_i     (sel_reload),
        .load_val_i (wr_data[PRE_W-1:0]),
        .tick_o     (tick_o),
        .run_o      (pre_run)
    );

    tct_rise_det u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (tick_o),
        .rise_o  (tick_rise)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_ch
        tct_channel #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .adv_i      (tick_rise),
            .start_i    (cnt_start[g]),
            .stop_i     (cnt_stop[g]),
            .cmp_we_i   (cmp_we_flat[g*NUM_CMP +: NUM_CMP]),
            .cmp_val_i  (wr_data[CNT_W-1:0]),
            .flag_clr_i (flag_clr_flat[g*NUM_CMP +: NUM_CMP]),
            .en_clr_i   (en_clr_flat[g*NUM_CMP +: NUM_CMP]),
            .count_o    (count_o[g*CNT_W +: CNT_W]),
            .flag_o     (flag_o[g*NUM_CMP +: NUM_CMP]),
            .en_o       (en_all[g*NUM_CMP +: NUM_CMP]),
            .run_o      (cnt_run[g]),
            .irq_o      (cnt_irq[g])
        );
    end

    assign irq_o = |cnt_irq;
endmodule

// File: rtl/tct_checker.sv
module tct_checker
    import tct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tick_o,
    input logic [NUM_CNT*CNT_W-1:0] count_o,
    input logic [FLAG_W-1:0]        flag_o,
    input logic                     irq_o,
    input logic                     pre_run,
    input logic                     pre_start,
    input logic                     tick_rise,
    input logic [NUM_CNT-1:0]       cnt_run,
    input logic [NUM_CNT-1:0]       cnt_start,
    input logic [FLAG_W-1:0]        cmp_we_flat,
    input logic [FLAG_W-1:0]        flag_clr_flat,
    input logic [FLAG_W-1:0]        en_all
);
    // R3: a stopped prescaler that is not restarted leaves the tick line alone
    a_r3_tick_holds_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_run && !pre_start) |=> $stable(tick_o));

    // R4: the edge detector never reports two rises back to back
    a_r4_rise_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |=> !tick_rise);

    // R11: no interrupt without a pending flag
    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !(|flag_o) |-> !irq_o);

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        // R4: a running counter steps by exactly one on a tick rise
        a_r4_step_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_rise && cnt_run[c] && !cnt_start[c])
            |=> count_o[c*CNT_W +: CNT_W] == CNT_W'($past(count_o[c*CNT_W +: CNT_W]) + 1));

        // R4: without a rise or a start the count does not move
        a_r4_hold_without_rise: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick_rise && !cnt_start[c]) |=> $stable(count_o[c*CNT_W +: CNT_W]));
    end

    for (genvar j = 0; j < FLAG_W; j++) begin : g_flag
        // R8: a compare write leaves the slot cleared and armed
        a_r8_cmp_write_rearms: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_we_flat[j] |=> (!flag_o[j] && en_all[j]));

        // R7: a flag survives until a clear or a compare write
        a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[j] && !flag_clr_flat[j] && !cmp_we_flat[j]) |=> flag_o[j]);
    end
endmodule

bind tick_chain_timer tct_checker #(.CNT_W(CNT_W)) u_tct_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_o        (tick_o),
    .count_o       (count_o),
    .flag_o        (flag_o),
    .irq_o         (irq_o),
    .pre_run       (pre_run),
    .pre_start     (pre_start),
    .tick_rise     (tick_rise),
    .cnt_run       (cnt_run),
    .cnt_start     (cnt_start),
    .cmp_we_flat   (cmp_we_flat),
    .flag_clr_flat (flag_clr_flat),
    .en_all        (en_all)
);

// File: tb/tb_tick_chain_timer.sv
module tb_tick_chain_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 180000;
    localparam int NVEC       = 6;
    // each entry: reload value in the upper half, target count in the lower half
    localparam logic [31:0] VEC [NVEC] = '{
        {16'd0, 16'd1}, {16'd0, 16'd5}, {16'd1, 16'd3},
        {16'd3, 16'd4}, {16'd6, 16'd2}, {16'd2, 16'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        tick;
    logic [31:0] count;
    logic [5:0]  flags;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_chain_timer dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick_o  (tick),
        .count_o (count),
        .flag_o  (flags),
        .irq_o   (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // write captured at the posedge between the two negedges; returns after it
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rc, n, r0, r1;
        logic [5:0]  rf;
        int k;

        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R1: reset state
        chk("R1 count", count, 32'h0);
        chk("R1 flags", {26'h0, flags}, 32'h0);
        chk("R1 tick/irq", {30'h0, tick, irq}, 32'h0);

        // table walk: R2 R4 R7 R8 R11
        for (int v = 0; v < NVEC; v++) begin
            rc = VEC[v][31:16];
            n  = VEC[v][15:0];
            k  = int'(rc) + 2 + 2 * (int'(rc) + 1) * (int'(n) - 1);
            wr(4'h1, 16'h0070);
            wr(4'h0, rc);
            wr(4'h8, n);                 // counter 0 slot A
            wr(4'h1, 16'h0007);
            wait_n(k - 1);
            chk("R4 count0 one early", {16'h0, count[15:0]}, {16'h0, n - 16'd1});
            chk("R4 count1 one early", {16'h0, count[31:16]}, {16'h0, n - 16'd1});
            chk("R7 flag not yet", {31'h0, flags[0]}, 32'h0);
            chk("R11 irq not yet", {31'h0, irq}, 32'h0);
            wait_n(1);
            chk("R4 count0 on time", {16'h0, count[15:0]}, {16'h0, n});
            chk("R4 count1 on time", {16'h0, count[31:16]}, {16'h0, n});
            chk("R7 R8 flag on match", {31'h0, flags[0]}, 32'h1);
            chk("R11 irq on match", {31'h0, irq}, 32'h1);
        end

        // R2 tick period with reload 3; counters stopped (R5)
        wr(4'h1, 16'h0070);
        wr(4'h0, 16'd3);
        r0 = count[15:0];
        wr(4'h1, 16'h0001);
        wait_n(3);
        chk("R2 tick before first match", {31'h0, tick}, 32'h0);
        wait_n(1);
        chk("R2 tick after first match", {31'h0, tick}, 32'h1);
        wait_n(3);
        chk("R2 tick held", {31'h0, tick}, 32'h1);
        wait_n(1);
        chk("R2 tick second toggle", {31'h0, tick}, 32'h0);
        chk("R5 stopped counter holds", {16'h0, count[15:0]}, {16'h0, r0});

        // R3 stopping the prescaler freezes the tick line
        wait_n(2);
        wr(4'h1, 16'h0010);
        rf[0] = tick;
        wait_n(12);
        chk("R3 tick frozen", {31'h0, tick}, {31'h0, rf[0]});

        // R5 stop counter 1 only
        wr(4'h1, 16'h0007);
        wait_n(20);
        wr(4'h1, 16'h0040);
        r0 = count[15:0];
        r1 = count[31:16];
        wait_n(40);
        chk("R5 counter1 held", {16'h0, count[31:16]}, {16'h0, r1});
        chk("R5 counter0 moved", {31'h0, (count[15:0] != r0)}, 32'h1);

        // R12 ignored addresses
        wr(4'h1, 16'h0070);
        r0 = count[15:0];
        r1 = count[31:16];
        rf = flags;
        rf[0] = irq;   // reuse only bit 0 after capture below
        rf = flags;
        wr(4'h4, 16'hFFFF);
        wr(4'h7, 16'hFFFF);
        wr(4'hB, 16'h0000);
        wr(4'hF, 16'h0000);
        chk("R12 flags unchanged", {26'h0, flags}, {26'h0, rf});
        chk("R12 counts unchanged", count, {r1, r0});

        // R9 match beats a clear in the same cycle, reload 0
        wr(4'h0, 16'd0);
        wr(4'h8, 16'd3);
        wr(4'h1, 16'h0007);
        wait_n(4);
        wr(4'h2, 16'h0001);          // lands on the edge where count becomes 3
        chk("R9 match wins over clear", {31'h0, flags[0]}, 32'h1);
        wr(4'h2, 16'h0001);
        chk("R9 clear takes effect", {31'h0, flags[0]}, 32'h0);

        // R6 R10 R11 wrap with reload 0
        wr(4'h1, 16'h0070);
        wr(4'h3, 16'h003F);
        wr(4'hE, 16'd2);             // counter 1 slot C
        wr(4'h1, 16'h0007);
        k = 2 * 65535;
        wait_n(1000);
        wr(4'h2, 16'h0020);
        wait_n(k - 1 - 1002);
        chk("R4 long run one early", {16'h0, count[31:16]}, 32'h0000FFFE);
        chk("R9 cleared flag stays clear", {31'h0, flags[5]}, 32'h0);
        chk("R10 flag set while disabled", {31'h0, flags[0]}, 32'h1);
        chk("R10 no irq from disabled", {31'h0, irq}, 32'h0);
        wait_n(1);
        chk("R6 top value", count, 32'hFFFF_FFFF);
        wait_n(2);
        chk("R6 wrap to zero", count, 32'h0);
        chk("R6 match on zero after wrap", {31'h0, flags[1]}, 32'h1);
        wait_n(4);
        chk("R6 count after wrap", {16'h0, count[31:16]}, 32'h2);
        chk("R6 R7 match after wrap", {31'h0, flags[5]}, 32'h1);
        chk("R11 irq from enabled slot", {31'h0, irq}, 32'h1);
        wr(4'h2, 16'h0020);
        chk("R11 irq drops after clear", {31'h0, irq}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule